// File: doc/BRIEF.md
# Burst Address and Transfer-Type Sequencer

This block sits on the master side of an AHB bus. It turns one burst request into the bus address and transfer type for every beat. The request carries a start address, a transfer size and a burst kind. The block then steps the address through the burst and marks each beat as a first transfer (NONSEQ) or a follow-on transfer (SEQ). It moves forward only when the bus signals ready. When the local data source is not ready, it fills the gap with BUSY or IDLE cycles. For an open-ended incrementing burst, it starts a new NONSEQ transfer whenever the address reaches a 1KB boundary.

Requests that break the bus rules are refused with a one-cycle error pulse, and no transfer is issued for them. The rules checked are a misaligned address, a size wider than the data bus, a fixed-length incrementing burst that would cross 1KB, and an open-ended burst of zero beats. A one-cycle done pulse marks the acceptance of the last beat. Arbitration and data movement belong to other blocks.

Top module: `ahb_burst_gen`

## Requirements
- R1: After reset, busTrans is IDLE (00), and burstActive, burstDone and startErr are low.
- R2: busTrans encodes IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. The first beat of a burst is NONSEQ and every later beat is SEQ, except as R5 states. The first busTrans after a start is NONSEQ if srcReady was high at the start edge, and IDLE if it was low.
- R3: A beat is 1<<startSize bytes. The burst kind is SINGLE=000 or INCR=001, or a fixed length: INCR4=011, INCR8=101, INCR16=111. SINGLE issues one beat and INCRn issues n beats. INCR issues incrLen beats. Each incrementing beat address is the previous one plus the beat size.
- R4: The wrapping kinds are WRAP4=010, WRAP8=100 and WRAP16=110. They issue n beats inside a block of n times the beat size, aligned to that size. The address wraps to the block base after the block's top beat.
- R5: In an INCR (001) burst, a beat whose address has bits [9:0] equal to zero, after the first, is issued as NONSEQ. The beats after it are SEQ.
- R6: While burstActive is high and busReady is low at a clock edge, busTrans and busAddr keep their values in the next cycle.
- R7: Suppose srcReady is low at an edge where busReady is high and the burst is not yet complete. The next busTrans is then BUSY if a SEQ beat is pending. It is IDLE if a NONSEQ beat is pending. The pending address is not advanced.
- R8: burstDone is high for exactly one cycle: the cycle after the edge that accepts the last beat. In that cycle busTrans is IDLE and burstActive is low.
- R9: A start request is refused in four cases: the address is not a multiple of the beat size; startSize exceeds BUS_BYTES_LOG2 (default 2); a fixed-length incrementing burst would pass a 1KB boundary (ending exactly on it is allowed); or an INCR burst has incrLen of 0. A refused request gives one startErr cycle, burstActive stays low and busTrans stays IDLE.
- R10: startReq is ignored while burstActive is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a new burst (taken when idle) |
| startAddr | input | ADDR_W | First beat address |
| startSize | input | 3 | Beat size code, bytes = 1<<code |
| startKind | input | 3 | Burst kind code |
| incrLen | input | LEN_W | Beat count for open-ended INCR |
| srcReady | input | 1 | Local data source can take/give the next beat |
| busReady | input | 1 | Bus ready; an address phase completes when high |
| busAddr | output | ADDR_W | Address of the current address phase |
| busTrans | output | 2 | Transfer type |
| busSize | output | 3 | Beat size code of the running burst |
| busBurst | output | 3 | Burst kind of the running burst |
| burstActive | output | 1 | A burst is in progress |
| burstDone | output | 1 | One-cycle pulse after the last beat |
| startErr | output | 1 | One-cycle pulse for a refused request |

## Verification
Directed bursts cover these cases:
- word WRAP4 from 0x34 and WRAP8 from 0x64, which show that wrapping returns to the block base rather than running on;
- INCR8 from 0x60;
- an open-ended INCR that runs through 0x400, which shows the boundary restart against plain SEQ continuation.

Random bursts mix every kind, sizes byte to word, and lengths up to 40. They also vary the rate of busReady and srcReady. This separates the hold behaviour (bus stall) from BUSY/IDLE insertion (source stall), and it checks that stray start requests during a burst are ignored. Refused requests cover each error cause, plus an INCR4 that ends exactly on 1KB, which must be accepted.

// File: rtl/burst_gen_pkg.sv
package burst_gen_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } transT;

  localparam logic [2:0] BK_SINGLE = 3'd0;
  localparam logic [2:0] BK_INCR   = 3'd1;
  localparam logic [2:0] BK_WRAP4  = 3'd2;
  localparam logic [2:0] BK_INCR4  = 3'd3;
  localparam logic [2:0] BK_WRAP8  = 3'd4;
  localparam logic [2:0] BK_INCR8  = 3'd5;
  localparam logic [2:0] BK_WRAP16 = 3'd6;
  localparam logic [2:0] BK_INCR16 = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic advance;
  } ctrlStrobeT;

  // beat count of a fixed-length kind, 0 for open-ended INCR
  function automatic logic [4:0] fixedBeats(input logic [2:0] kind);
    case (kind)
      BK_SINGLE:           fixedBeats = 5'd1;
      BK_WRAP4, BK_INCR4:  fixedBeats = 5'd4;
      BK_WRAP8, BK_INCR8:  fixedBeats = 5'd8;
      BK_WRAP16, BK_INCR16: fixedBeats = 5'd16;
      default:             fixedBeats = 5'd0;
    endcase
  endfunction

  function automatic logic isWrap(input logic [2:0] kind);
    isWrap = (kind == BK_WRAP4) || (kind == BK_WRAP8) || (kind == BK_WRAP16);
  endfunction

  function automatic logic isFixedIncr(input logic [2:0] kind);
    isFixedIncr = (kind == BK_INCR4) || (kind == BK_INCR8) || (kind == BK_INCR16);
  endfunction
endpackage

// File: rtl/burst_gen_dp.sv
module burst_gen_dp
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int BUS_BYTES_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        startSize,
  input  logic [2:0]        startKind,
  input  logic [1:0]        curTrans,
  output logic              startOk,
  output logic              nextAtKb,
  output logic [ADDR_W-1:0] busAddr,
  output logic [2:0]        busSize,
  output logic [2:0]        busBurst
);
  localparam int KB_BITS = 10;
  localparam logic [KB_BITS+1:0] KB_SPAN = (KB_BITS+2)'(1 << KB_BITS);

  logic [ADDR_W-1:0] addrQ;
  logic [2:0]        sizeQ;
  logic [2:0]        kindQ;

  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] wrapMask;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] alignMask;
  logic [KB_BITS+1:0] spanBytes;
  logic              aligned, sizeOk, kbOk;

  always_comb begin
    stepBytes = ADDR_W'(1) << sizeQ;
    wrapMask  = (ADDR_W'(fixedBeats(kindQ)) << sizeQ) - ADDR_W'(1);
    incAddr   = addrQ + stepBytes;
    nextAddr  = isWrap(kindQ) ? ((addrQ & ~wrapMask) | (incAddr & wrapMask)) : incAddr;
    nextAtKb  = (nextAddr[KB_BITS-1:0] == '0);

    alignMask = (ADDR_W'(1) << startSize) - ADDR_W'(1);
    aligned   = ((startAddr & alignMask) == '0);
    sizeOk    = (int'(startSize) <= BUS_BYTES_LOG2);
    spanBytes = (KB_BITS+2)'(fixedBeats(startKind)) << startSize;
    kbOk      = !isFixedIncr(startKind) ||
                (({2'b00, startAddr[KB_BITS-1:0]} + spanBytes) <= KB_SPAN);
    startOk   = aligned && sizeOk && kbOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      sizeQ <= '0;
      kindQ <= BK_SINGLE;
    end else if (strobe.loadStart) begin
      addrQ <= startAddr;
      sizeQ <= startSize;
      kindQ <= startKind;
    end else if (strobe.advance) begin
      addrQ <= nextAddr;
    end
  end

  assign busAddr  = addrQ;
  assign busSize  = sizeQ;
  assign busBurst = kindQ;

  // R9
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    curTrans[1] |-> ((addrQ & ((ADDR_W'(1) << sizeQ) - ADDR_W'(1))) == '0));

  // R4
  wrap_in_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && isWrap(kindQ)) |=>
      (((addrQ ^ $past(addrQ)) & ~$past(wrapMask)) == '0));

  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !isWrap(kindQ)) |=> (addrQ == $past(addrQ) + $past(stepBytes)));

  // R5
  kb_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curTrans == TR_SEQ && kindQ == BK_INCR) |-> (addrQ[KB_BITS-1:0] != '0));
endmodule

// File: rtl/burst_gen_ctrl.sv
module burst_gen_ctrl
  import burst_gen_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [2:0]       startKind,
  input  logic [LEN_W-1:0] incrLen,
  input  logic             startOk,
  input  logic             nextAtKb,
  input  logic [2:0]       kindQ,
  input  logic             srcReady,
  input  logic             busReady,
  output ctrlStrobeT       strobe,
  output logic [1:0]       busTrans,
  output logic             burstActive,
  output logic             burstDone,
  output logic             startErr
);
  transT            transQ;
  logic             activeQ;
  logic [LEN_W-1:0] beatsLeft;
  logic             pendNonseq;

  logic             beatTaken, lastBeat, goodStart, pendNext;
  logic [LEN_W-1:0] startBeats;

  function automatic transT transFor(input logic pend, input logic src);
    if (src) transFor = pend ? TR_NONSEQ : TR_SEQ;
    else     transFor = pend ? TR_IDLE : TR_BUSY;
  endfunction

  always_comb begin
    beatTaken  = activeQ && busReady && (transQ == TR_NONSEQ || transQ == TR_SEQ);
    lastBeat   = (beatsLeft == LEN_W'(1));
    startBeats = (startKind == BK_INCR) ? incrLen : LEN_W'(fixedBeats(startKind));
    goodStart  = !activeQ && startReq && startOk && (startBeats != '0);
    pendNext   = beatTaken ? ((kindQ == BK_INCR) && nextAtKb) : pendNonseq;
    strobe.loadStart = goodStart;
    strobe.advance   = beatTaken && !lastBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      transQ     <= TR_IDLE;
      activeQ    <= 1'b0;
      beatsLeft  <= '0;
      pendNonseq <= 1'b0;
      burstDone  <= 1'b0;
      startErr   <= 1'b0;
    end else begin
      burstDone <= 1'b0;
      startErr  <= 1'b0;
      if (!activeQ) begin
        if (goodStart) begin
          activeQ    <= 1'b1;
          beatsLeft  <= startBeats;
          pendNonseq <= 1'b1;
          transQ     <= transFor(1'b1, srcReady);
        end else if (startReq) begin
          startErr <= 1'b1;
        end
      end else if (busReady) begin
        if (beatTaken && lastBeat) begin
          activeQ    <= 1'b0;
          beatsLeft  <= '0;
          pendNonseq <= 1'b0;
          transQ     <= TR_IDLE;
          burstDone  <= 1'b1;
        end else begin
          if (beatTaken) beatsLeft <= beatsLeft - LEN_W'(1);
          pendNonseq <= pendNext;
          transQ     <= transFor(pendNext, srcReady);
        end
      end
    end
  end

  assign busTrans    = transQ;
  assign burstActive = activeQ;

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && !busReady) |=> $stable(transQ));

  // R8
  done_after_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> ($past(busReady) && $past(transQ[1]) && !activeQ && transQ == TR_IDLE));

  // R2
  no_seq_after_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (transQ == TR_SEQ) |-> ($past(transQ) != TR_IDLE));

  // R9
  err_no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    startErr |-> (!activeQ && transQ == TR_IDLE));

  // R7
  busy_in_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (transQ == TR_BUSY) |-> activeQ);
endmodule

// File: rtl/ahb_burst_gen.sv
module ahb_burst_gen
  import burst_gen_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 8,
  parameter int BUS_BYTES_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        startSize,
  input  logic [2:0]        startKind,
  input  logic [LEN_W-1:0]  incrLen,
  input  logic              srcReady,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busTrans,
  output logic [2:0]        busSize,
  output logic [2:0]        busBurst,
  output logic              burstActive,
  output logic              burstDone,
  output logic              startErr
);
  ctrlStrobeT strobe;
  logic       startOk;
  logic       nextAtKb;

  burst_gen_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startKind(startKind),
    .incrLen(incrLen), .startOk(startOk), .nextAtKb(nextAtKb), .kindQ(busBurst),
    .srcReady(srcReady), .busReady(busReady), .strobe(strobe), .busTrans(busTrans),
    .burstActive(burstActive), .burstDone(burstDone), .startErr(startErr)
  );

  burst_gen_dp #(.ADDR_W(ADDR_W), .BUS_BYTES_LOG2(BUS_BYTES_LOG2)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .startSize(startSize), .startKind(startKind), .curTrans(busTrans),
    .startOk(startOk), .nextAtKb(nextAtKb), .busAddr(busAddr),
    .busSize(busSize), .busBurst(busBurst)
  );
endmodule

// File: tb/tb_ahb_burst_gen.sv
module tb_ahb_burst_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] startAddr = '0;
  logic [2:0]  startSize = '0;
  logic [2:0]  startKind = '0;
  logic [7:0]  incrLen = '0;
  logic        srcReady = 1'b1;
  logic        busReady = 1'b1;
  logic [31:0] busAddr;
  logic [1:0]  busTrans;
  logic [2:0]  busSize, busBurst;
  logic        burstActive, burstDone, startErr;

  int checks = 0;
  int fails = 0;
  bit summaryDone = 0;

  always #10 clk = ~clk;

  ahb_burst_gen dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .startSize(startSize), .startKind(startKind), .incrLen(incrLen),
    .srcReady(srcReady), .busReady(busReady), .busAddr(busAddr),
    .busTrans(busTrans), .busSize(busSize), .busBurst(busBurst),
    .burstActive(burstActive), .burstDone(burstDone), .startErr(startErr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
  endtask

  function automatic int beatsOf(input logic [2:0] kd, input logic [7:0] len);
    case (kd)
      3'd0: beatsOf = 1;
      3'd1: beatsOf = int'(len);
      3'd2, 3'd3: beatsOf = 4;
      3'd4, 3'd5: beatsOf = 8;
      default: beatsOf = 16;
    endcase
  endfunction

  function automatic bit wrapKind(input logic [2:0] kd);
    wrapKind = (kd == 3'd2) || (kd == 3'd4) || (kd == 3'd6);
  endfunction

  function automatic logic [31:0] expAddr(input logic [31:0] a, input logic [2:0] sz,
                                          input logic [2:0] kd, input int idx);
    logic [31:0] bytes = 32'd1 << sz;
    logic [31:0] blk;
    if (wrapKind(kd)) begin
      blk = 32'(beatsOf(kd, 8'd0)) * bytes - 1;
      expAddr = (a & ~blk) | ((a + 32'(idx) * bytes) & blk);
    end else begin
      expAddr = a + 32'(idx) * bytes;
    end
  endfunction

  task automatic runBurst(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] kd,
                          input logic [7:0] len, input int rdyPct, input int srcPct, input bit poke);
    int beats = beatsOf(kd, len);
    int idx = 0;
    bit first = 1, finished = 0, pend, stray = 0;
    logic pBus, pSrc;
    logic [1:0] pTrans, expT;
    logic [31:0] pAddr, ea;
    string tag;
    tag = (kd == 3'd1) ? "R5" : (wrapKind(kd) ? "R4" : "R3");
    startAddr = a; startSize = sz; startKind = kd; incrLen = len;
    startReq = 1'b1;
    pSrc = ($urandom % 100) < srcPct; srcReady = pSrc;
    pBus = ($urandom % 100) < rdyPct; busReady = pBus;
    @(negedge clk);
    startReq = 1'b0;
    for (int cyc = 0; cyc < 4000 && !finished; cyc++) begin
      if (!first && !pBus) begin
        check(busTrans == pTrans && busAddr == pAddr, "R6 hold", {busTrans, busAddr[29:0]}, {pTrans, pAddr[29:0]});
      end else begin
        ea = expAddr(a, sz, kd, idx);
        pend = (idx == 0) || (kd == 3'd1 && ea[9:0] == 10'd0);
        expT = pSrc ? (pend ? 2'b10 : 2'b11) : (pend ? 2'b00 : 2'b01);
        check(busTrans == expT, pSrc ? "R2 trans" : "R7 fill", 32'(busTrans), 32'(expT));
        if (busTrans[1]) check(busAddr == ea, tag, busAddr, ea);
      end
      if (burstDone || startErr || !burstActive) stray = 1;
      first = 0; pTrans = busTrans; pAddr = busAddr;
      pBus = ($urandom % 100) < rdyPct; busReady = pBus;
      pSrc = ($urandom % 100) < srcPct; srcReady = pSrc;
      if (poke) begin
        startReq = ($urandom % 4) == 0;  // R10 stray requests while busy
        startAddr = $urandom; startKind = 3'($urandom); startSize = 3'($urandom);
      end
      if (pBus && busTrans[1]) begin
        idx++;
        if (idx == beats) finished = 1;
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    check(!stray, "R10 no stray done/err mid burst", 32'(stray), 0);
    check(finished && burstDone && !burstActive && busTrans == 2'b00, "R8 done",
          {29'd0, burstDone, burstActive, finished}, 32'd5);
    @(negedge clk);
    check(!burstDone && busTrans == 2'b00, "R8 pulse", {30'd0, burstDone, busTrans[1]}, 0);
  endtask

  task automatic tryBad(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] kd,
                        input logic [7:0] len, input bit expectErr);
    startAddr = a; startSize = sz; startKind = kd; incrLen = len;
    busReady = 1'b1; srcReady = 1'b1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (expectErr) begin
      check(startErr && !burstActive && busTrans == 2'b00, "R9 refused",
            {30'd0, startErr, burstActive}, 32'd2);
      @(negedge clk);
      check(!startErr && !burstActive && busTrans == 2'b00, "R9 no issue",
            {30'd0, startErr, burstActive}, 0);
    end else begin
      check(!startErr && burstActive && busTrans == 2'b10 && busAddr == a, "R9 boundary end allowed",
            busAddr, a);
      while (burstActive) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(busTrans == 2'b00 && !burstActive && !burstDone && !startErr, "R1 reset",
          {27'd0, busTrans, burstActive, burstDone, startErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busTrans == 2'b00 && !burstActive, "R1 after release", 32'(busTrans), 0);

    // directed patterns
    runBurst(32'h34, 3'd2, 3'd2, 8'd0, 100, 100, 0);   // WRAP4 word
    runBurst(32'h64, 3'd2, 3'd4, 8'd0, 70, 70, 0);     // WRAP8 word
    runBurst(32'h60, 3'd2, 3'd5, 8'd0, 100, 100, 0);   // INCR8 word
    runBurst(32'h3F0, 3'd2, 3'd1, 8'd8, 100, 100, 0);  // INCR over 1KB
    runBurst(32'h3F8, 3'd2, 3'd1, 8'd6, 60, 50, 1);    // stalls near 1KB
    runBurst(32'h1001, 3'd0, 3'd0, 8'd0, 100, 100, 0); // SINGLE byte
    runBurst(32'h3F2, 3'd1, 3'd6, 8'd0, 50, 60, 1);    // WRAP16 halfword

    // refused and boundary starts
    tryBad(32'h22, 3'd2, 3'd3, 8'd0, 1);     // misaligned
    tryBad(32'h40, 3'd3, 3'd0, 8'd0, 1);     // wider than bus
    tryBad(32'h3F8, 3'd2, 3'd3, 8'd0, 1);    // INCR4 crosses 1KB
    tryBad(32'h80, 3'd2, 3'd1, 8'd0, 1);     // INCR of zero beats
    tryBad(32'h3F0, 3'd2, 3'd3, 8'd0, 0);    // INCR4 ending on 1KB

    // constrained random bursts
    for (int n = 0; n < 60; n++) begin
      logic [2:0] kd = 3'($urandom % 8);
      logic [2:0] sz = 3'($urandom % 3);
      logic [7:0] len = 8'(1 + $urandom % 40);
      logic [31:0] a = $urandom & ~((32'd1 << sz) - 1);
      logic [31:0] span = 32'(beatsOf(kd, len)) << sz;
      if (kd == 3'd1 && ($urandom % 2) == 1) a = {a[31:10], 10'h3C0};
      if ((kd == 3'd3 || kd == 3'd5 || kd == 3'd7) && ({22'd0, a[9:0]} + span) > 32'd1024)
        a = a - span;
      runBurst(a, sz, kd, len, 40 + int'($urandom % 61), 50 + int'($urandom % 51), 1'($urandom % 2));
    end

    summary();
    $finish;
  end
endmodule